// File: doc/BRIEF.md
# DDR Access Command Sequencer

This block turns one host access at a time into a DDR command sequence. A host request gives a byte address, a write flag, a size code and a flag saying whether the requester may issue full-line bursts. Line-capable requesters are cache fills, DMA and multi-register moves.

The sequencer performs each access in this order:

1. It opens the row with an activate command.
2. It inserts a configurable number of no-operation cycles to cover the activate-to-column delay.
3. It issues the column read or write.
4. It counts the data clocks of the transfer.
5. For a write, it waits a configurable recovery time.
6. It signals completion.

A read shorter than a full line is cut off with a burst-terminate command in the cycle right after the read. This frees the bus instead of running the memory's fixed burst of eight beats. A full line is eight 16-bit beats and always runs to the end.

A single row is treated as open only for the duration of one access. There is no page tracking, refresh or initialisation. Sampling of the returned read data is outside this block.

Top module: `ddr_cmd_seq`

## Requirements
- R1: After synchronous reset the command output is NOP (`0111`), ready is high, done is low, the data mask is all ones and the strobe enable is low.
- R2: A request accepted at a clock edge (valid and ready both high) gives an activate (`0111` becomes `0011`, bits ordered chip select, row strobe, column strobe, write enable) in the next cycle. The address output carries the row and the bank output carries the bank. Byte address layout from bit 0 upward: lane bit, column, row, bank.
- R3: After the activate, exactly `cfg_trcd_i` NOP cycles follow (zero allowed). Then a read (`0101`) or a write (`0100`) is issued, with the zero-extended column on the address output.
- R4: For a read that is not a full line, a burst terminate (`0110`) appears in the cycle directly after the read command.
- R5: A read or write of size code 3 with the burst flag set is a full line. It issues no terminate and occupies 4 data clocks (8 beats).
- R6: Size code 3 without the burst flag is handled as a single 32-bit transfer. It takes one data clock, and a read issues a terminate.
- R7: Byte (code 0), 16-bit (code 1) and 32-bit (code 2) transfers each occupy exactly one data clock. A 32-bit transfer is two beats in one clock.
- R8: During write data clocks the strobe enable is high for every clock. The mask (bit 1 upper lane, 1 = masked) is `10` for a byte at an even address, `01` for a byte at an odd address, and `00` for wider writes. Outside write data clocks the mask is `11` and the strobe enable is low.
- R9: After the last write data clock, exactly `cfg_twr_i` NOP cycles pass before completion. Reads have no such wait.
- R10: Completion is one cycle with done and ready both high, in the cycle after the last data or recovery cycle. Ready stays low from acceptance until then, and requests presented while ready is low have no effect.
- R11: Both delay settings are sampled at acceptance. Changing them during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Sequencer idle and able to accept |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 line |
| req_burst_i | input | 1 | Requester may use line size |
| req_addr_i | input | ADDR_W | Byte address |
| cfg_trcd_i | input | CNT_W | NOP cycles between activate and column command |
| cfg_twr_i | input | CNT_W | Recovery cycles after write data |
| ddr_cmd_o | output | 4 | Command {CS,RAS,CAS,WE} |
| ddr_addr_o | output | ROW_W | Row or column address |
| ddr_ba_o | output | BA_W | Bank address |
| ddr_dm_o | output | BUS_BYTES | Write data mask, 1 = masked |
| dqs_oe_o | output | 1 | Drive all data strobes |
| done_o | output | 1 | Access complete pulse |

## Verification
A bad phase or delay count in the sequencer shows up at the command pins within one cycle of the slip. A terminate arrives early, late or not at all, or the column command lands off its slot. The reference model compares the full command, mask, strobe and handshake vector on every clock, so the first wrong cycle is reported.

A stale size or lane latch is caught differently. It surfaces as a wrong mask or a wrong data-clock count, and only within the access that used it. Stale settings from an earlier request therefore cannot hide behind later ones.

// File: rtl/ddr_cmd_seq_pkg.sv
package ddr_cmd_seq_pkg;

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_BST = 4'b0110;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LINE = 2'd3
  } xfer_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_GAP,
    ST_ISSUE,
    ST_XFER,
    ST_RECOV
  } seq_state_e;

endpackage

// File: rtl/ddr_size_decode.sv
module ddr_size_decode
  import ddr_cmd_seq_pkg::*;
#(
  parameter int BUS_BYTES  = 2,
  parameter int LINE_BYTES = 16,
  parameter int CNT_W      = 4,
  localparam int LANE_W    = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1
) (
  input  logic [1:0]           size_i,
  input  logic                 burst_i,
  input  logic                 write_i,
  input  logic [LANE_W-1:0]    lane_i,
  output logic                 line_o,
  output logic                 term_o,
  output logic [CNT_W-1:0]     dclk_o,
  output logic [BUS_BYTES-1:0] mask_o
);

  // beats per size on the bus, two beats per clock
  localparam int WORD_BEATS = (4 > BUS_BYTES) ? 4 / BUS_BYTES : 1;
  localparam int LINE_BEATS = LINE_BYTES / BUS_BYTES;
  localparam int WORD_CLKS  = (WORD_BEATS + 1) / 2;
  localparam int LINE_CLKS  = (LINE_BEATS + 1) / 2;

  always_comb begin
    line_o = (size_i == SZ_LINE) && burst_i;
    term_o = !write_i && !line_o;
    if (line_o)
      dclk_o = CNT_W'(LINE_CLKS);
    else if (size_i == SZ_BYTE || size_i == SZ_HALF)
      dclk_o = CNT_W'(1);
    else
      dclk_o = CNT_W'(WORD_CLKS);
    mask_o = '0;
    if (size_i == SZ_BYTE) begin
      mask_o = '1;
      mask_o[lane_i] = 1'b0;
    end
  end

endmodule

// File: rtl/ddr_down_counter.sv
module ddr_down_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_o <= '0;
    else if (load_i)
      cnt_o <= load_val_i;
    else if (cnt_o != '0)
      cnt_o <= cnt_o - 1'b1;
  end

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_cmd_seq_pkg::*;
#(
  parameter int COL_W      = 9,
  parameter int ROW_W      = 13,
  parameter int BA_W       = 2,
  parameter int BUS_BYTES  = 2,
  parameter int LINE_BYTES = 16,
  parameter int CNT_W      = 4,
  parameter int ADDR_W     = $clog2(BUS_BYTES) + COL_W + ROW_W + BA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [1:0]           req_size_i,
  input  logic                 req_burst_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [CNT_W-1:0]     cfg_trcd_i,
  input  logic [CNT_W-1:0]     cfg_twr_i,
  output logic [3:0]           ddr_cmd_o,
  output logic [ROW_W-1:0]     ddr_addr_o,
  output logic [BA_W-1:0]      ddr_ba_o,
  output logic [BUS_BYTES-1:0] ddr_dm_o,
  output logic                 dqs_oe_o,
  output logic                 done_o
);

  localparam int LANE_W  = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;
  localparam int LANE_LO = $clog2(BUS_BYTES);
  localparam int ROW_LO  = LANE_LO + COL_W;
  localparam int BA_LO   = ROW_LO + ROW_W;

  seq_state_e st;

  // latched request
  logic                 wr_l, term_l;
  logic [CNT_W-1:0]     dclk_l, trcd_l, twr_l;
  logic [BUS_BYTES-1:0] mask_l;
  logic [COL_W-1:0]     col_l;

  // decoder outputs
  logic                 dec_line, dec_term;
  logic [CNT_W-1:0]     dec_dclk;
  logic [BUS_BYTES-1:0] dec_mask;
  logic [LANE_W-1:0]    lane;

  // counter
  logic                 cnt_load;
  logic [CNT_W-1:0]     cnt_val, cnt;
  logic                 cnt_last;

  // registered outputs
  logic [3:0]           cmd_q;
  logic [ROW_W-1:0]     addr_q;
  logic [BA_W-1:0]      ba_q;
  logic [BUS_BYTES-1:0] dm_q;
  logic                 oe_q, rdy_q, done_q;

  generate
    if (BUS_BYTES > 1) begin : g_lane
      assign lane = req_addr_i[LANE_W-1:0];
    end else begin : g_nolane
      assign lane = 1'b0;
    end
  endgenerate

  ddr_size_decode #(
    .BUS_BYTES (BUS_BYTES),
    .LINE_BYTES(LINE_BYTES),
    .CNT_W     (CNT_W)
  ) u_dec (
    .size_i (req_size_i),
    .burst_i(req_burst_i),
    .write_i(req_write_i),
    .lane_i (lane),
    .line_o (dec_line),
    .term_o (dec_term),
    .dclk_o (dec_dclk),
    .mask_o (dec_mask)
  );

  ddr_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load_i    (cnt_load),
    .load_val_i(cnt_val),
    .cnt_o     (cnt)
  );

  assign cnt_last = (cnt == CNT_W'(1));

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (st)
      ST_ACT:   begin cnt_load = 1'b1; cnt_val = trcd_l; end
      ST_ISSUE: begin cnt_load = 1'b1; cnt_val = dclk_l; end
      ST_XFER:  if (cnt_last) begin cnt_load = 1'b1; cnt_val = twr_l; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      wr_l   <= 1'b0;
      term_l <= 1'b0;
      dclk_l <= '0;
      trcd_l <= '0;
      twr_l  <= '0;
      mask_l <= '1;
      col_l  <= '0;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      dm_q   <= '1;
      oe_q   <= 1'b0;
      rdy_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid_i) begin
            wr_l   <= req_write_i;
            term_l <= dec_term;
            dclk_l <= dec_dclk;
            mask_l <= dec_mask;
            trcd_l <= cfg_trcd_i;
            twr_l  <= cfg_twr_i;
            col_l  <= req_addr_i[ROW_LO-1:LANE_LO];
            cmd_q  <= CMD_ACT;
            addr_q <= req_addr_i[BA_LO-1:ROW_LO];
            ba_q   <= req_addr_i[BA_LO+BA_W-1:BA_LO];
            rdy_q  <= 1'b0;
            st     <= ST_ACT;
          end
        end
        ST_ACT, ST_GAP: begin
          if ((st == ST_ACT && trcd_l == '0) || (st == ST_GAP && cnt_last)) begin
            cmd_q  <= wr_l ? CMD_WR : CMD_RD;
            addr_q <= ROW_W'(col_l);
            st     <= ST_ISSUE;
          end else begin
            st <= ST_GAP;
          end
        end
        ST_ISSUE: begin
          cmd_q <= term_l ? CMD_BST : CMD_NOP;
          dm_q  <= wr_l ? mask_l : '1;
          oe_q  <= wr_l;
          st    <= ST_XFER;
        end
        ST_XFER: begin
          if (cnt_last) begin
            dm_q <= '1;
            oe_q <= 1'b0;
            if (wr_l && twr_l != '0) begin
              st <= ST_RECOV;
            end else begin
              st     <= ST_IDLE;
              rdy_q  <= 1'b1;
              done_q <= 1'b1;
            end
          end
        end
        ST_RECOV: begin
          if (cnt_last) begin
            st     <= ST_IDLE;
            rdy_q  <= 1'b1;
            done_q <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = rdy_q;
  assign ddr_cmd_o   = cmd_q;
  assign ddr_addr_o  = addr_q;
  assign ddr_ba_o    = ba_q;
  assign ddr_dm_o    = dm_q;
  assign dqs_oe_o    = oe_q;
  assign done_o      = done_q;

endmodule

// File: rtl/ddr_cmd_seq_checker.sv
module ddr_cmd_seq_checker #(
  parameter int BUS_BYTES = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid_i,
  input logic                 req_ready_o,
  input logic [3:0]           ddr_cmd_o,
  input logic [BUS_BYTES-1:0] ddr_dm_o,
  input logic                 dqs_oe_o,
  input logic                 done_o
);

  // R2: acceptance leads to an activate on the next cycle
  a_r2_act_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_ready_o) |=> (ddr_cmd_o == 4'b0011));

  // R4: a terminate only ever follows a read directly
  a_r4_bst_after_read: assert property (@(posedge clk) disable iff (rst)
    (ddr_cmd_o == 4'b0110) |-> ($past(ddr_cmd_o) == 4'b0101));

  // R8: mask is all ones whenever strobes are not driven
  a_r8_mask_idle: assert property (@(posedge clk) disable iff (rst)
    !dqs_oe_o |-> (ddr_dm_o == '1));

  // R8: strobes are driven only after a write command
  a_r8_oe_after_write: assert property (@(posedge clk) disable iff (rst)
    $rose(dqs_oe_o) |-> ($past(ddr_cmd_o) == 4'b0100));

  // R10: ready is low whenever a command other than NOP is on the bus
  a_r10_busy_no_ready: assert property (@(posedge clk) disable iff (rst)
    (ddr_cmd_o != 4'b0111) |-> !req_ready_o);

  // R10: completion comes with ready and lasts one cycle
  a_r10_done_ready: assert property (@(posedge clk) disable iff (rst)
    done_o |-> req_ready_o);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10: ready can only rise together with completion
  a_r10_ready_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ready_o) |-> done_o);

endmodule

bind ddr_cmd_seq ddr_cmd_seq_checker #(.BUS_BYTES(BUS_BYTES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .ddr_cmd_o  (ddr_cmd_o),
  .ddr_dm_o   (ddr_dm_o),
  .dqs_oe_o   (dqs_oe_o),
  .done_o     (done_o)
);

// File: tb/ddr_cmd_seq_tb.sv
module ddr_cmd_seq_tb;

  localparam int COL_W = 9, ROW_W = 13, BA_W = 2, BUS_BYTES = 2, CNT_W = 4;
  localparam int ADDR_W = 1 + COL_W + ROW_W + BA_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic                 req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [1:0]           req_size = '0;
  logic [ADDR_W-1:0]    req_addr = '0;
  logic [CNT_W-1:0]     cfg_trcd = '0, cfg_twr = '0;
  logic                 req_ready, dqs_oe, done;
  logic [3:0]           ddr_cmd;
  logic [ROW_W-1:0]     ddr_addr;
  logic [BA_W-1:0]      ddr_ba;
  logic [BUS_BYTES-1:0] ddr_dm;

  ddr_cmd_seq u_dut (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_size_i(req_size), .req_burst_i(req_burst),
    .req_addr_i(req_addr), .cfg_trcd_i(cfg_trcd), .cfg_twr_i(cfg_twr),
    .ddr_cmd_o(ddr_cmd), .ddr_addr_o(ddr_addr), .ddr_ba_o(ddr_ba),
    .ddr_dm_o(ddr_dm), .dqs_oe_o(dqs_oe), .done_o(done)
  );

  typedef struct packed {
    logic [3:0]       cmd;
    logic             chk_a;
    logic [ROW_W-1:0] addr;
    logic [BA_W-1:0]  ba;
    logic [1:0]       dm;
    logic             oe;
    logic             rdy;
    logic             dn;
  } exp_t;

  typedef struct {
    bit              w;
    bit [1:0]        sz;
    bit              b;
    bit [ADDR_W-1:0] a;
    bit [CNT_W-1:0]  trcd;
    bit [CNT_W-1:0]  twr;
  } req_t;

  exp_t  exp_q[$];
  string tag_q[$];
  req_t  pend[$];
  int    checks = 0, errors = 0;
  bit    finished = 0;

  function automatic exp_t mk(logic [3:0] c, logic [1:0] dm, logic oe,
                              logic rdy, logic dn);
    exp_t e;
    e = '0; e.cmd = c; e.dm = dm; e.oe = oe; e.rdy = rdy; e.dn = dn;
    return e;
  endfunction

  function automatic void push(exp_t e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endfunction

  // reference model: full expected cycle list for one accepted request
  function automatic void model(req_t r);
    exp_t e;
    bit line, term;
    int dcl;
    logic [1:0] m;
    line = (r.sz == 2'd3) && r.b;
    term = !r.w && !line;
    dcl  = line ? 4 : 1;
    if (r.sz == 2'd0) m = r.a[0] ? 2'b01 : 2'b10; else m = 2'b00;
    e = mk(4'b0011, 2'b11, 0, 0, 0);
    e.chk_a = 1; e.addr = r.a[ADDR_W-BA_W-1:1+COL_W]; e.ba = r.a[ADDR_W-1:ADDR_W-BA_W];
    push(e, "R2");
    for (int i = 0; i < r.trcd; i++) push(mk(4'b0111, 2'b11, 0, 0, 0), "R3/R11");
    e = mk(r.w ? 4'b0100 : 4'b0101, 2'b11, 0, 0, 0);
    e.chk_a = 1; e.addr = ROW_W'(r.a[COL_W:1]); e.ba = r.a[ADDR_W-1:ADDR_W-BA_W];
    push(e, "R3");
    for (int i = 0; i < dcl; i++) begin
      e = mk((i == 0 && term) ? 4'b0110 : 4'b0111, r.w ? m : 2'b11, r.w, 0, 0);
      if (i == 0 && term) push(e, (r.sz == 2'd3) ? "R6" : "R4");
      else push(e, r.w ? "R8" : (line ? "R5" : "R7"));
    end
    if (r.w) for (int i = 0; i < r.twr; i++) push(mk(4'b0111, 2'b11, 0, 0, 0), "R9/R11");
    push(mk(4'b0111, 2'b11, 0, 1, 1), "R10");
  endfunction

  task automatic step();
    exp_t e;
    string t;
    bit bad;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
    end else begin
      e = mk(4'b0111, 2'b11, 0, 1, 0);
      t = "R1/R10";
    end
    checks++;
    bad = (ddr_cmd !== e.cmd) || (ddr_dm !== e.dm) || (dqs_oe !== e.oe) ||
          (req_ready !== e.rdy) || (done !== e.dn) ||
          (e.chk_a && ((ddr_addr !== e.addr) || (ddr_ba !== e.ba)));
    if (bad) begin
      errors++;
      $display("FAIL %s t=%0t actual cmd=%b addr=%h ba=%h dm=%b oe=%b rdy=%b done=%b expected cmd=%b addr=%h ba=%h dm=%b oe=%b rdy=%b done=%b",
               t, $time, ddr_cmd, ddr_addr, ddr_ba, ddr_dm, dqs_oe, req_ready, done,
               e.cmd, e.addr, e.ba, e.dm, e.oe, e.rdy, e.dn);
    end
    // drive: a held request while busy must be ignored (R10)
    if (pend.size() > 0) begin
      req_valid = 1; req_write = pend[0].w; req_size = pend[0].sz;
      req_burst = pend[0].b; req_addr = pend[0].a;
      cfg_trcd = pend[0].trcd; cfg_twr = pend[0].twr;
      if (e.rdy) begin
        model(pend[0]);
        void'(pend.pop_front());
      end
    end else begin
      // R11: settings change freely outside acceptance
      req_valid = 0; cfg_trcd = 4'hF; cfg_twr = 4'hE;
    end
  endtask

  function automatic void add(bit w, bit [1:0] sz, bit b, bit [ADDR_W-1:0] a,
                              bit [CNT_W-1:0] trcd, bit [CNT_W-1:0] twr);
    req_t r;
    r.w = w; r.sz = sz; r.b = b; r.a = a; r.trcd = trcd; r.twr = twr;
    pend.push_back(r);
  endfunction

  task automatic drain();
    while (pend.size() > 0 || exp_q.size() > 0) step();
    repeat (3) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: idle state after reset
    repeat (4) step();
    // R2 R3 R4 R7: sub-line reads
    add(0, 2'd0, 0, 25'h0ABCDEF, 4'd2, 4'd0);
    drain();
    add(0, 2'd1, 1, 25'h1234567, 4'd0, 4'd3);
    drain();
    add(0, 2'd2, 0, 25'h1FFFFFF, 4'd3, 4'd0);
    drain();
    // R5: full line read, no terminate
    add(0, 2'd3, 1, 25'h0000020, 4'd1, 4'd0);
    drain();
    // R6: line size without burst flag
    add(0, 2'd3, 0, 25'h1555555, 4'd2, 4'd0);
    drain();
    // R8 R9: writes with masks and recovery
    add(1, 2'd0, 0, 25'h0000100, 4'd2, 4'd2);
    drain();
    add(1, 2'd0, 0, 25'h0000101, 4'd1, 4'd1);
    drain();
    add(1, 2'd2, 0, 25'h0F0F0F0, 4'd0, 4'd0);
    drain();
    add(1, 2'd3, 1, 25'h1AAAAAA, 4'd1, 4'd3);
    drain();
    add(1, 2'd1, 0, 25'h0333333, 4'd4, 4'd1);
    drain();
    // R10 R11: back-to-back, held while busy, settings differ per request
    add(0, 2'd0, 0, 25'h0111111, 4'd1, 4'd0);
    add(1, 2'd0, 0, 25'h0222223, 4'd0, 4'd2);
    add(0, 2'd3, 1, 25'h1444440, 4'd2, 4'd0);
    add(1, 2'd3, 0, 25'h0777777, 4'd3, 4'd5);
    add(0, 2'd1, 0, 25'h0000000, 4'd0, 4'd0);
    drain();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule